// File: doc/BRIEF.md
# Receive Subaddress Ping-Pong Buffer Manager

This block keeps the data-block pointers for the subaddresses of a serial-bus remote terminal that shares memory with a host. Each subaddress owns one pointer register. That register names the 32-word block into which the next incoming message is written. A receive or broadcast subaddress in double-buffer mode has a second block whose start address differs only in bit 5. When a message ends cleanly, the manager flips that bit, so the block just filled becomes the one the host reads. A message that ends with an error leaves the pointer alone. The block it was partly writing therefore never reaches the host.

The message engine gives a start pulse carrying the subaddress and its direction, then one strobe per data word, then one end pulse marked either valid or error. For every word the manager returns a write enable and an address, formed as the pointer plus a saturating word index. The host reaches four register kinds through one port: per-subaddress control words, per-subaddress pointers, a sticky status word it clears by writing ones, and an interrupt mask.

To read safely, the host clears the enable bit for a subaddress. It then reads the block at the pointer with bit 5 inverted, and sets the enable bit again.

Top module: `sa_dbuf_mgr`

## Requirements
- R1: After reset, the pointer of subaddress s reads s*64. Every control word, the status word, the mask and `irq` read zero.
- R2: `wordWe` is high only in a cycle where `wordStrobe` arrives inside an open message (opened by `msgStart`, closed by an end pulse). Its `wordAddr` is the pointer plus the word index. The index is 0 for the first word after `msgStart`, counts up by one per word and stays at 31 from the 32nd word onward.
- R3: A valid end pulse (`msgEndValid`) on a receive message (`msgRx`=1) whose control word has bit 0 (double-buffer enable) set inverts bit 5 of that subaddress's pointer on the next edge. No other pointer bit changes.
- R4: An error end pulse (`msgEndError`, which wins if both end pulses arrive together) never changes the pointer.
- R5: With control bit 0 clear, the subaddress is in single-message mode and its pointer stays fixed across valid messages.
- R6: A transmit message (`msgRx`=0) never changes the pointer.
- R7: A host write in the same cycle as a valid end pulse takes priority. A control write clearing bit 0 for that subaddress prevents the flip, and a pointer write leaves exactly the written value.
- R8: Status bit 2 (subaddress hit) is set by a valid receive end when control bit 1 is set and either the expected-count field (control bits 7:2) is zero or the number of words received, counted up to a limit of 32, is at least that field.
- R9: Status bits are bit 0 valid end, bit 1 error end, bit 2 subaddress hit, and bit 3 overrun (a word arriving after 32 words of the same message). The bits are sticky. Writing ones to the status kind clears them, except that a bit being set in the same cycle stays set.
- R10: `irq` is high exactly when some status bit and the same mask bit are both set. It follows an event one cycle after the end pulse.
- R11: Host kinds on `hostKind` are 0 control, 1 pointer, 2 status, 3 mask. Reads are combinational on `hostRdata`. Writes act at the clock edge where `hostWr` is high, and `hostSa` is ignored for status and mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| msgStart | input | 1 | Opens a message, latching subaddress and direction |
| msgSa | input | SA_W (5) | Subaddress of the message being opened |
| msgRx | input | 1 | 1 for receive or broadcast, 0 for transmit |
| wordStrobe | input | 1 | One data word of the open message |
| msgEndValid | input | 1 | Message finished without error |
| msgEndError | input | 1 | Message finished with an error |
| wordWe | output | 1 | Data word write enable to shared memory |
| wordAddr | output | PTR_W (16) | Shared-memory address for the data word |
| hostWr | input | 1 | Host register write strobe |
| hostKind | input | 2 | Register kind: control, pointer, status, mask |
| hostSa | input | SA_W (5) | Subaddress for control and pointer access |
| hostWdata | input | DATA_W (16) | Host write data |
| hostRdata | output | DATA_W (16) | Host read data |
| irq | output | 1 | Masked interrupt request |

## Verification
On every cycle the assertions check four things. A write enable appears only with a word strobe. Every data address lies inside the 32-word window of the current pointer. A valid receive end changes no pointer bit other than bit 5. Error ends and transmit ends leave the pointer alone, and the interrupt rises only after a message event or a host write. The bench scenarios cover the rest: the reset values of every subaddress, index saturation and the overrun flag, host priority in the same cycle as a message end, the expected-count threshold for the subaddress hit, the rule that a set beats a clear, and masking.

// File: rtl/sa_dbuf_pkg.sv
package sa_dbuf_pkg;

  // Host register kinds selected by hostKind
  typedef enum logic [1:0] {
    KIND_CTRL = 2'd0,
    KIND_PTR  = 2'd1,
    KIND_STAT = 2'd2,
    KIND_MASK = 2'd3
  } hostKind_t;

  // Control word fields
  localparam int CW_DB_EN   = 0;
  localparam int CW_SA_IRQ  = 1;
  localparam int CW_EXP_LSB = 2;

  // Status / mask bit positions
  localparam int ST_EOM = 0;
  localparam int ST_ERR = 1;
  localparam int ST_HIT = 2;
  localparam int ST_OVR = 3;
  localparam int ST_W   = 4;

  // Strobes from message control to datapath
  typedef struct packed {
    logic wordWr;
    logic endValid;
    logic endError;
    logic overrun;
    logic rx;
  } msgStb_t;

endpackage

// File: rtl/sa_dbuf_ctrl.sv
module sa_dbuf_ctrl
  import sa_dbuf_pkg::*;
#(
  parameter int SA_W  = 5,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             msgStart,
  input  logic [SA_W-1:0]  msgSa,
  input  logic             msgRx,
  input  logic             wordStrobe,
  input  logic             msgEndValid,
  input  logic             msgEndError,
  output msgStb_t          stb,
  output logic [SA_W-1:0]  curSa,
  output logic [IDX_W-1:0] wordIdx,
  output logic [IDX_W:0]   wordCnt
);

  localparam logic [IDX_W-1:0] IDX_LAST = '1;
  localparam logic [IDX_W:0]   CNT_FULL = {1'b1, {IDX_W{1'b0}}};

  logic msgOpen;
  logic rxQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      msgOpen <= 1'b0;
      rxQ     <= 1'b0;
      curSa   <= '0;
      wordIdx <= '0;
      wordCnt <= '0;
    end else if (msgStart) begin
      msgOpen <= 1'b1;
      rxQ     <= msgRx;
      curSa   <= msgSa;
      wordIdx <= '0;
      wordCnt <= '0;
    end else if (msgOpen) begin
      if (wordStrobe) begin
        if (wordIdx != IDX_LAST) wordIdx <= wordIdx + 1'b1;
        if (wordCnt != CNT_FULL) wordCnt <= wordCnt + 1'b1;
      end
      if (msgEndValid || msgEndError) msgOpen <= 1'b0;
    end
  end

  always_comb begin
    stb.wordWr   = msgOpen && wordStrobe;
    stb.endValid = msgOpen && msgEndValid && !msgEndError;
    stb.endError = msgOpen && msgEndError;
    stb.overrun  = msgOpen && wordStrobe && (wordCnt == CNT_FULL);
    stb.rx       = rxQ;
  end

endmodule

// File: rtl/sa_dbuf_dp.sv
module sa_dbuf_dp
  import sa_dbuf_pkg::*;
#(
  parameter int SA_W   = 5,
  parameter int IDX_W  = 5,
  parameter int PTR_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  msgStb_t           stb,
  input  logic [SA_W-1:0]   curSa,
  input  logic [IDX_W-1:0]  wordIdx,
  input  logic [IDX_W:0]    wordCnt,
  input  logic              hostWr,
  input  logic [1:0]        hostKind,
  input  logic [SA_W-1:0]   hostSa,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic [PTR_W-1:0]  curPtr,
  output logic [PTR_W-1:0]  wordAddr,
  output logic              wordWe,
  output logic              irq
);

  localparam int NUM_SA = 1 << SA_W;
  localparam int CNT_W  = IDX_W + 1;

  logic [PTR_W-1:0]  ptrMem  [NUM_SA];
  logic [DATA_W-1:0] ctrlMem [NUM_SA];
  logic [ST_W-1:0]   status;
  logic [ST_W-1:0]   maskQ;

  logic              ctrlWrHit;
  logic [DATA_W-1:0] effCtrl;
  logic [CNT_W-1:0]  expWords;
  logic              doToggle;
  logic              saHit;
  logic [ST_W-1:0]   setV;
  logic [ST_W-1:0]   clrV;

  // Host control write to the message's subaddress overrides the stored word
  assign ctrlWrHit = hostWr && (hostKind == KIND_CTRL) && (hostSa == curSa);
  assign effCtrl   = ctrlWrHit ? hostWdata : ctrlMem[curSa];
  assign expWords  = effCtrl[CW_EXP_LSB +: CNT_W];
  assign doToggle  = stb.endValid && stb.rx && effCtrl[CW_DB_EN];
  assign saHit     = stb.endValid && stb.rx && effCtrl[CW_SA_IRQ] &&
                     ((expWords == '0) || (wordCnt >= expWords));

  for (genvar g = 0; g < NUM_SA; g++) begin : gSa
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ptrMem[g]  <= PTR_W'(g) << (IDX_W + 1);
        ctrlMem[g] <= '0;
      end else begin
        if (hostWr && (hostKind == KIND_CTRL) && (hostSa == SA_W'(g)))
          ctrlMem[g] <= hostWdata;
        if (hostWr && (hostKind == KIND_PTR) && (hostSa == SA_W'(g)))
          ptrMem[g] <= hostWdata[PTR_W-1:0];
        else if (doToggle && (curSa == SA_W'(g)))
          ptrMem[g][IDX_W] <= ~ptrMem[g][IDX_W];
      end
    end
  end

  always_comb begin
    setV         = '0;
    setV[ST_EOM] = stb.endValid;
    setV[ST_ERR] = stb.endError;
    setV[ST_HIT] = saHit;
    setV[ST_OVR] = stb.overrun;
    clrV = (hostWr && (hostKind == KIND_STAT)) ? hostWdata[ST_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      status <= '0;
      maskQ  <= '0;
    end else begin
      status <= (status & ~clrV) | setV;
      if (hostWr && (hostKind == KIND_MASK)) maskQ <= hostWdata[ST_W-1:0];
    end
  end

  always_comb begin
    case (hostKind)
      KIND_CTRL: hostRdata = ctrlMem[hostSa];
      KIND_PTR:  hostRdata = DATA_W'(ptrMem[hostSa]);
      KIND_STAT: hostRdata = DATA_W'(status);
      default:   hostRdata = DATA_W'(maskQ);
    endcase
  end

  assign curPtr   = ptrMem[curSa];
  assign wordAddr = curPtr + PTR_W'(wordIdx);
  assign wordWe   = stb.wordWr;
  assign irq      = |(status & maskQ);

endmodule

// File: rtl/sa_dbuf_mgr.sv
module sa_dbuf_mgr
  import sa_dbuf_pkg::*;
#(
  parameter int SA_W   = 5,
  parameter int IDX_W  = 5,
  parameter int PTR_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              msgStart,
  input  logic [SA_W-1:0]   msgSa,
  input  logic              msgRx,
  input  logic              wordStrobe,
  input  logic              msgEndValid,
  input  logic              msgEndError,
  output logic              wordWe,
  output logic [PTR_W-1:0]  wordAddr,
  input  logic              hostWr,
  input  logic [1:0]        hostKind,
  input  logic [SA_W-1:0]   hostSa,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              irq
);

  msgStb_t          stb;
  logic [SA_W-1:0]  curSa;
  logic [IDX_W-1:0] wordIdx;
  logic [IDX_W:0]   wordCnt;
  logic [PTR_W-1:0] curPtr;

  sa_dbuf_ctrl #(.SA_W(SA_W), .IDX_W(IDX_W)) ctrlInst (
    .clk(clk), .rstN(rstN),
    .msgStart(msgStart), .msgSa(msgSa), .msgRx(msgRx),
    .wordStrobe(wordStrobe), .msgEndValid(msgEndValid), .msgEndError(msgEndError),
    .stb(stb), .curSa(curSa), .wordIdx(wordIdx), .wordCnt(wordCnt)
  );

  sa_dbuf_dp #(.SA_W(SA_W), .IDX_W(IDX_W), .PTR_W(PTR_W), .DATA_W(DATA_W)) dpInst (
    .clk(clk), .rstN(rstN),
    .stb(stb), .curSa(curSa), .wordIdx(wordIdx), .wordCnt(wordCnt),
    .hostWr(hostWr), .hostKind(hostKind), .hostSa(hostSa),
    .hostWdata(hostWdata), .hostRdata(hostRdata),
    .curPtr(curPtr), .wordAddr(wordAddr), .wordWe(wordWe), .irq(irq)
  );

endmodule

// File: rtl/sa_dbuf_mgr_chk.sv
module sa_dbuf_mgr_chk
  import sa_dbuf_pkg::*;
#(
  parameter int PTR_W = 16,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             msgStart,
  input logic             hostWr,
  input logic             wordStrobe,
  input logic             wordWe,
  input logic [PTR_W-1:0] wordAddr,
  input logic             irq,
  input logic [PTR_W-1:0] curPtr,
  input msgStb_t          stb
);

  localparam logic [PTR_W-1:0] FLIP_BIT = PTR_W'(1) << IDX_W;
  localparam logic [PTR_W-1:0] WIN_LAST = PTR_W'((1 << IDX_W) - 1);

  assert_we_gated_R2: assert property (@(posedge clk) disable iff (!rstN)
    wordWe |-> wordStrobe);

  assert_addr_window_R2: assert property (@(posedge clk) disable iff (!rstN)
    wordWe |-> (PTR_W'(wordAddr - curPtr) <= WIN_LAST));

  assert_only_bit5_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.endValid && stb.rx && !hostWr && !msgStart)
      |=> (((curPtr ^ $past(curPtr)) & ~FLIP_BIT) == '0));

  assert_error_keeps_ptr_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.endError && !hostWr && !msgStart) |=> $stable(curPtr));

  assert_tx_keeps_ptr_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.endValid && !stb.rx && !hostWr && !msgStart) |=> $stable(curPtr));

  assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(stb.endValid || stb.endError || stb.overrun || hostWr));

endmodule

bind sa_dbuf_mgr sa_dbuf_mgr_chk #(.PTR_W(PTR_W), .IDX_W(IDX_W)) chkInst (
  .clk(clk), .rstN(rstN), .msgStart(msgStart), .hostWr(hostWr),
  .wordStrobe(wordStrobe), .wordWe(wordWe), .wordAddr(wordAddr),
  .irq(irq), .curPtr(curPtr), .stb(stb)
);

// File: tb/sa_dbuf_mgr_test.sv
module sa_dbuf_mgr_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        msgStart = 1'b0;
  logic [4:0]  msgSa = '0;
  logic        msgRx = 1'b0;
  logic        wordStrobe = 1'b0;
  logic        msgEndValid = 1'b0;
  logic        msgEndError = 1'b0;
  logic        wordWe;
  logic [15:0] wordAddr;
  logic        hostWr = 1'b0;
  logic [1:0]  hostKind = '0;
  logic [4:0]  hostSa = '0;
  logic [15:0] hostWdata = '0;
  logic [15:0] hostRdata;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [15:0] expPtr  [32];
  logic [15:0] expCtrl [32];
  logic [3:0]  expStat = '0;
  logic [3:0]  expMask = '0;

  always #2 clk = ~clk;

  sa_dbuf_mgr uut (
    .clk(clk), .rstN(rstN), .msgStart(msgStart), .msgSa(msgSa), .msgRx(msgRx),
    .wordStrobe(wordStrobe), .msgEndValid(msgEndValid), .msgEndError(msgEndError),
    .wordWe(wordWe), .wordAddr(wordAddr), .hostWr(hostWr), .hostKind(hostKind),
    .hostSa(hostSa), .hostWdata(hostWdata), .hostRdata(hostRdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [1:0] k, input int sa, input logic [15:0] d);
    hostWr = 1'b1; hostKind = k; hostSa = 5'(sa); hostWdata = d;
    @(negedge clk);
    hostWr = 1'b0;
    case (k)
      2'd0: expCtrl[sa] = d;
      2'd1: expPtr[sa] = d;
      2'd2: expStat = expStat & ~d[3:0];
      default: expMask = d[3:0];
    endcase
  endtask

  task automatic checkPtr(input int sa, input string req);
    hostKind = 2'd1; hostSa = 5'(sa);
    #1 check(req, 32'(hostRdata), 32'(expPtr[sa]));
    @(negedge clk);
  endtask

  task automatic checkStat(input string req);
    hostKind = 2'd2;
    #1 check(req, 32'(hostRdata), 32'(expStat));
    check(req, 32'(irq), 32'(|(expStat & expMask)));
    @(negedge clk);
  endtask

  // One message; optional host write in the same cycle as the end pulse
  task automatic runMsg(input int sa, input bit rx, input int n, input bit valid,
                        input bit hostOn, input logic [1:0] hk, input logic [15:0] hd);
    logic [15:0] base;
    logic [15:0] effCtrl;
    logic [5:0]  expW;
    int          got;
    logic [3:0]  setV;
    logic [3:0]  clrV;
    msgStart = 1'b1; msgSa = 5'(sa); msgRx = rx;
    @(negedge clk);
    msgStart = 1'b0;
    base = expPtr[sa];
    for (int i = 0; i < n; i++) begin
      wordStrobe = 1'b1;
      #1;
      check("R2 we", 32'(wordWe), 32'd1);
      check("R2 addr", 32'(wordAddr), 32'(16'(base + 16'((i > 31) ? 31 : i))));
      @(negedge clk);
    end
    wordStrobe = 1'b0;
    if (valid) msgEndValid = 1'b1; else msgEndError = 1'b1;
    if (hostOn) begin
      hostWr = 1'b1; hostKind = hk; hostSa = 5'(sa); hostWdata = hd;
    end
    @(negedge clk);
    msgEndValid = 1'b0; msgEndError = 1'b0; hostWr = 1'b0;
    // model update
    effCtrl = (hostOn && hk == 2'd0) ? hd : expCtrl[sa];
    if (hostOn && hk == 2'd0) expCtrl[sa] = hd;
    if (hostOn && hk == 2'd3) expMask = hd[3:0];
    expW = effCtrl[7:2];
    got = (n > 32) ? 32 : n;
    setV = '0;
    setV[0] = valid;
    setV[1] = !valid;
    setV[2] = valid && rx && effCtrl[1] && ((expW == 0) || (got >= int'(expW)));
    setV[3] = (n > 32);
    clrV = (hostOn && hk == 2'd2) ? hd[3:0] : 4'd0;
    expStat = (expStat & ~clrV) | setV;
    if (hostOn && hk == 2'd1) expPtr[sa] = hd;
    else if (valid && rx && effCtrl[0]) expPtr[sa][5] = ~expPtr[sa][5];
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int s = 0; s < 32; s++) begin
      expPtr[s] = 16'(s * 64);
      expCtrl[s] = '0;
    end

    // R1: reset state of every subaddress
    for (int s = 0; s < 32; s++) begin
      checkPtr(s, "R1 ptr");
      hostKind = 2'd0; hostSa = 5'(s);
      #1 check("R1 ctrl", 32'(hostRdata), 32'd0);
      @(negedge clk);
    end
    checkStat("R1 status");
    hostKind = 2'd3;
    #1 check("R1 mask", 32'(hostRdata), 32'd0);
    @(negedge clk);

    // R2/R3/R4 sweep over all subaddresses
    for (int s = 0; s < 32; s++) begin
      hostWrite(2'd0, s, 16'h0001);
      check("R2 idle we", 32'(wordWe), 32'd0);
      runMsg(s, 1'b1, s + 1, 1'b1, 1'b0, 2'd0, 16'h0);
      checkPtr(s, "R3 toggle");
      runMsg(s, 1'b1, 3, 1'b0, 1'b0, 2'd0, 16'h0);
      checkPtr(s, "R4 error keeps");
      runMsg(s, 1'b1, 2, 1'b1, 1'b0, 2'd0, 16'h0);
      checkPtr(s, "R3 toggle back");
    end
    hostWrite(2'd2, 0, 16'h000F);
    checkStat("R11 status clear");

    // R5: single-message mode
    hostWrite(2'd0, 3, 16'h0000);
    runMsg(3, 1'b1, 5, 1'b1, 1'b0, 2'd0, 16'h0);
    checkPtr(3, "R5 no toggle");

    // R6: transmit message
    runMsg(4, 1'b0, 4, 1'b1, 1'b0, 2'd0, 16'h0);
    checkPtr(4, "R6 tx no toggle");

    // R7: host priority at message end
    runMsg(5, 1'b1, 2, 1'b1, 1'b1, 2'd0, 16'h0000);
    checkPtr(5, "R7 ctrl clear wins");
    hostWrite(2'd0, 5, 16'h0001);
    runMsg(5, 1'b1, 2, 1'b1, 1'b1, 2'd1, 16'h0ABC);
    checkPtr(5, "R7 ptr write wins");
    runMsg(5, 1'b1, 3, 1'b1, 1'b0, 2'd0, 16'h0);
    checkPtr(5, "R7 toggle after host ptr");

    // R8: subaddress hit threshold
    hostWrite(2'd2, 0, 16'h000F);
    hostWrite(2'd0, 6, 16'h0013);
    runMsg(6, 1'b1, 3, 1'b1, 1'b0, 2'd0, 16'h0);
    checkStat("R8 below count");
    runMsg(6, 1'b1, 4, 1'b1, 1'b0, 2'd0, 16'h0);
    checkStat("R8 at count");
    hostWrite(2'd2, 0, 16'h000F);
    runMsg(6, 1'b0, 5, 1'b1, 1'b0, 2'd0, 16'h0);
    checkStat("R8 tx no hit");
    hostWrite(2'd0, 7, 16'h0002);
    runMsg(7, 1'b1, 1, 1'b1, 1'b0, 2'd0, 16'h0);
    checkStat("R8 zero count");
    runMsg(6, 1'b1, 40, 1'b1, 1'b0, 2'd0, 16'h0);
    checkStat("R8 over count");

    // R9: overrun, stickiness, set beats clear
    hostWrite(2'd2, 0, 16'h000F);
    runMsg(8, 1'b1, 33, 1'b1, 1'b0, 2'd0, 16'h0);
    checkStat("R9 overrun");
    runMsg(8, 1'b1, 1, 1'b0, 1'b1, 2'd2, 16'h000F);
    checkStat("R9 set beats clear");
    hostWrite(2'd2, 0, 16'h0002);
    checkStat("R9 w1c");

    // R10: masked interrupt
    hostWrite(2'd3, 0, 16'h0001);
    runMsg(9, 1'b1, 1, 1'b0, 1'b0, 2'd0, 16'h0);
    checkStat("R10 masked err");
    runMsg(9, 1'b1, 1, 1'b1, 1'b0, 2'd0, 16'h0);
    checkStat("R10 eom irq");
    hostWrite(2'd3, 0, 16'h0000);
    checkStat("R10 mask off");
    hostWrite(2'd3, 0, 16'h000A);
    checkStat("R10 mask err");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule